// File: doc/BRIEF.md
# DMA Read-Back Sequencer

This block forms the read side of a DMA controller's control port. A 7-bit selection mask chooses which internal values are presented to the host. Successive reads step through only the selected values, always in a fixed order, and start again at the first one after the last. One of the selectable values is a status byte. The block builds it from the controller's live state at the moment of each read.

The host loads a new mask, or issues a restart command, to rebuild the selection and return to its first entry. A status-only command narrows the selection to the status byte alone. The byte counter, the two port address counters and the status flags arrive as live inputs. The read data is registered and changes only on a read strobe.

Top module: `dma_readback_seq`

## Requirements
- R1: After reset, `rd_data` holds 0x38 before any read. The selection mask is empty, so a read then returns the status byte.
- R2: Mask bit k selects source k. The sources, and the order in which they are read, are: bit 0 status byte, bit 1 `byte_cnt[7:0]`, bit 2 `byte_cnt[15:8]`, bit 3 `addr_a[7:0]`, bit 4 `addr_a[15:8]`, bit 5 `addr_b[7:0]`, bit 6 `addr_b[15:8]`.
- R3: A pulse on `mask_ld` stores `mask_in` as the mask. A pulse on `seq_restart` keeps the current mask. Either one makes the next read return the lowest selected source.
- R4: A pulse on `status_only` sets the mask to 0x01 and restarts the sequence. Every read after it returns the status byte. If it arrives in the same cycle as `mask_ld`, it takes priority.
- R5: Each read returns the selected source at the current position and then advances the position. The read after the highest selected source returns the lowest selected source again.
- R6: Status byte encoding:
  - bit 0 = `ctl_en`
  - bit 3 = 1
  - bit 4 = NOT `match_hit`
  - bit 5 = NOT `block_done`
  - bits 2, 6 and 7 = 0
- R7: Status bit 1 is 1 exactly when `xfer_mode` is not 1 and `rdy_now` differs from `rdy_pol`.
- R8: With an empty mask, every read returns the freshly computed status byte.
- R9: Each read captures the status inputs and counters as they are in the cycle of the read strobe.
- R10: `rd_data` does not change in a cycle without `rd_stb`, whatever the other inputs do.
- R11: If a read and a rebuild command fall in the same cycle, the read returns the entry from the old position. The following read returns the first entry of the rebuilt selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_stb | input | 1 | Read strobe, one read per cycle high |
| mask_ld | input | 1 | Load `mask_in` as selection mask |
| mask_in | input | 7 | New selection mask |
| seq_restart | input | 1 | Restart sequence with current mask |
| status_only | input | 1 | Select the status byte only |
| ctl_en | input | 1 | Controller enabled |
| xfer_mode | input | 2 | Transfer mode |
| rdy_now | input | 1 | Current ready state |
| rdy_pol | input | 1 | Configured ready polarity |
| match_hit | input | 1 | A match has occurred |
| block_done | input | 1 | End of block reached |
| byte_cnt | input | 16 | Live byte counter |
| addr_a | input | 16 | Live port A address counter |
| addr_b | input | 16 | Live port B address counter |
| rd_data | output | 8 | Registered read data |

## Verification
A stale or wrong position shows on the very next read: a source appears out of order, a source is skipped, or the wrap happens one read early or late. A mask that was not stored or rebuilt correctly shows within one sequence of reads as a wrong set of returned bytes. An error in the status encoding shows on the first read of the status byte under the input pattern that exercises the faulty bit. The bench therefore reads each sequence past its wrap point and checks every returned byte.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;
  localparam int SRC_N  = 7;
  localparam int PTR_W  = $clog2(SRC_N + 1);
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;

  localparam logic [DATA_W-1:0] RESET_DATA = 8'h38;

  // status byte bit positions
  localparam int ST_EN     = 0;
  localparam int ST_RDY    = 1;
  localparam int ST_ONE    = 3;
  localparam int ST_NOMTCH = 4;
  localparam int ST_NOEND  = 5;

  typedef enum logic [PTR_W-1:0] {
    SRC_STATUS = 3'd0,
    SRC_LEN_LO = 3'd1,
    SRC_LEN_HI = 3'd2,
    SRC_A_LO   = 3'd3,
    SRC_A_HI   = 3'd4,
    SRC_B_LO   = 3'd5,
    SRC_B_HI   = 3'd6
  } src_e;
endpackage

// File: rtl/dma_rb_pick.sv
module dma_rb_pick
  import dma_rb_pkg::*;
#(
  parameter int N  = SRC_N,
  parameter int IW = PTR_W
) (
  input  logic [N-1:0]  sel_mask,
  input  logic [IW-1:0] want,
  output logic [IW-1:0] pick_idx,
  output logic [IW-1:0] sel_count
);
  logic [IW-1:0] run;
  logic [IW-1:0] idx;

  // position of the want-th set bit, counting from bit 0
  always_comb begin
    run = '0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_mask[i]) begin
        if (run == want) idx = IW'(i);
        run = run + IW'(1);
      end
    end
  end

  assign pick_idx  = idx;
  assign sel_count = run;
endmodule

// File: rtl/dma_rb_status.sv
module dma_rb_status
  import dma_rb_pkg::*;
(
  input  logic              ctl_en,
  input  logic [1:0]        xfer_mode,
  input  logic              rdy_now,
  input  logic              rdy_pol,
  input  logic              match_hit,
  input  logic              block_done,
  output logic [DATA_W-1:0] status_byte
);
  always_comb begin
    status_byte            = '0;
    status_byte[ST_EN]     = ctl_en;
    status_byte[ST_RDY]    = (xfer_mode != 2'd1) && (rdy_now != rdy_pol);
    status_byte[ST_ONE]    = 1'b1;
    status_byte[ST_NOMTCH] = ~match_hit;
    status_byte[ST_NOEND]  = ~block_done;
  end
endmodule

// File: rtl/dma_rb_srcmux.sv
module dma_rb_srcmux
  import dma_rb_pkg::*;
(
  input  logic [PTR_W-1:0]  src_idx,
  input  logic [DATA_W-1:0] status_byte,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [CNT_W-1:0]  addr_a,
  input  logic [CNT_W-1:0]  addr_b,
  output logic [DATA_W-1:0] src_data
);
  always_comb begin
    case (src_e'(src_idx))
      SRC_STATUS: src_data = status_byte;
      SRC_LEN_LO: src_data = byte_cnt[DATA_W-1:0];
      SRC_LEN_HI: src_data = byte_cnt[CNT_W-1:DATA_W];
      SRC_A_LO:   src_data = addr_a[DATA_W-1:0];
      SRC_A_HI:   src_data = addr_a[CNT_W-1:DATA_W];
      SRC_B_LO:   src_data = addr_b[DATA_W-1:0];
      SRC_B_HI:   src_data = addr_b[CNT_W-1:DATA_W];
      default:    src_data = '0;
    endcase
  end
endmodule

// File: rtl/dma_readback_seq.sv
module dma_readback_seq
  import dma_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              mask_ld,
  input  logic [SRC_N-1:0]  mask_in,
  input  logic              seq_restart,
  input  logic              status_only,
  input  logic              ctl_en,
  input  logic [1:0]        xfer_mode,
  input  logic              rdy_now,
  input  logic              rdy_pol,
  input  logic              match_hit,
  input  logic              block_done,
  input  logic [CNT_W-1:0]  byte_cnt,
  input  logic [CNT_W-1:0]  addr_a,
  input  logic [CNT_W-1:0]  addr_b,
  output logic [DATA_W-1:0] rd_data
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [SRC_N-1:0]  mask_q, mask_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              mask_en, ptr_en, data_en;

  logic [PTR_W-1:0]  ptr_eff;
  logic [PTR_W-1:0]  pick_idx;
  logic [PTR_W-1:0]  sel_count;
  logic [DATA_W-1:0] status_byte;
  logic [DATA_W-1:0] src_data;
  logic              rebuild;

  dma_rb_status u_status (
    .ctl_en      (ctl_en),
    .xfer_mode   (xfer_mode),
    .rdy_now     (rdy_now),
    .rdy_pol     (rdy_pol),
    .match_hit   (match_hit),
    .block_done  (block_done),
    .status_byte (status_byte)
  );

  dma_rb_pick #(.N(SRC_N), .IW(PTR_W)) u_pick (
    .sel_mask  (mask_q),
    .want      (ptr_eff),
    .pick_idx  (pick_idx),
    .sel_count (sel_count)
  );

  dma_rb_srcmux u_mux (
    .src_idx     (pick_idx),
    .status_byte (status_byte),
    .byte_cnt    (byte_cnt),
    .addr_a      (addr_a),
    .addr_b      (addr_b),
    .src_data    (src_data)
  );

  assign rebuild = status_only | mask_ld | seq_restart;
  assign ptr_eff = (ptr_q >= sel_count) ? '0 : ptr_q;

  // next state
  always_comb begin
    mask_en = status_only | mask_ld;
    mask_d  = status_only ? SRC_N'(1) : mask_in;

    data_en = rd_stb;
    data_d  = (sel_count == '0) ? status_byte : src_data;

    ptr_en  = rebuild | (rd_stb && (sel_count != '0));
    ptr_d   = rebuild ? '0 : ptr_eff + PTR_W'(1);
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
      data_q <= RESET_DATA;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (ptr_en)  ptr_q  <= ptr_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign rd_data = data_q;
endmodule

// File: rtl/dma_readback_seq_chk.sv
module dma_readback_seq_chk
  import dma_rb_pkg::*;
(
  input logic              clk,
  input logic              rst_int_n,
  input logic              rd_stb,
  input logic              mask_ld,
  input logic [SRC_N-1:0]  mask_in,
  input logic              seq_restart,
  input logic              status_only,
  input logic [SRC_N-1:0]  mask_q,
  input logic [PTR_W-1:0]  ptr_q,
  input logic [PTR_W-1:0]  sel_count,
  input logic [DATA_W-1:0] rd_data
);
  assert_ptr_restart_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask_ld || seq_restart || status_only) |=> (ptr_q == '0));

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask_ld && !status_only) |=> (mask_q == $past(mask_in)));

  assert_status_only_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    status_only |=> (mask_q == SRC_N'(1)));

  assert_ptr_bound_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    ptr_q <= sel_count);

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_stb |=> $stable(rd_data));
endmodule

bind dma_readback_seq dma_readback_seq_chk u_chk (
  .clk         (clk),
  .rst_int_n   (rst_int_n),
  .rd_stb      (rd_stb),
  .mask_ld     (mask_ld),
  .mask_in     (mask_in),
  .seq_restart (seq_restart),
  .status_only (status_only),
  .mask_q      (mask_q),
  .ptr_q       (ptr_q),
  .sel_count   (sel_count),
  .rd_data     (rd_data)
);

// File: tb/dma_readback_seq_tb.sv
module dma_readback_seq_tb;
  logic        clk;
  logic        rst_n;
  logic        rd_stb, mask_ld, seq_restart, status_only;
  logic [6:0]  mask_in;
  logic        ctl_en, rdy_now, rdy_pol, match_hit, block_done;
  logic [1:0]  xfer_mode;
  logic [15:0] byte_cnt, addr_a, addr_b;
  logic [7:0]  rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dma_readback_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .mask_ld(mask_ld),
    .mask_in(mask_in), .seq_restart(seq_restart), .status_only(status_only),
    .ctl_en(ctl_en), .xfer_mode(xfer_mode), .rdy_now(rdy_now),
    .rdy_pol(rdy_pol), .match_hit(match_hit), .block_done(block_done),
    .byte_cnt(byte_cnt), .addr_a(addr_a), .addr_b(addr_b), .rd_data(rd_data)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic logic [7:0] stat_exp();
    logic [7:0] s;
    s = 8'h08;
    s[0] = ctl_en;
    s[1] = (xfer_mode != 2'd1) && (rdy_now != rdy_pol);
    s[4] = ~match_hit;
    s[5] = ~block_done;
    return s;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%02h expected %02h", req, act, exp);
    end
  endtask

  // one read; result sampled at the following falling edge
  task automatic rd_once();
    @(negedge clk) rd_stb = 1;
    @(negedge clk) rd_stb = 0;
  endtask

  task automatic pulse(input int which, input logic [6:0] m);
    @(negedge clk);
    mask_in = m;
    case (which)
      0: mask_ld = 1;
      1: seq_restart = 1;
      default: status_only = 1;
    endcase
    @(negedge clk);
    mask_ld = 0; seq_restart = 0; status_only = 0;
  endtask

  task automatic t_reset();
    check("R1 reset value", rd_data, 8'h38);
    rd_once();
    check("R8 empty mask read", rd_data, stat_exp());
    rd_once();
    check("R8 empty mask second read", rd_data, stat_exp());
  endtask

  task automatic t_status();
    ctl_en = 1; rd_once(); check("R6 enable bit", rd_data, 8'h39);
    match_hit = 1; rd_once(); check("R6 match bit", rd_data, 8'h29);
    block_done = 1; rd_once(); check("R6 end bit", rd_data, 8'h09);
    ctl_en = 0; match_hit = 0; block_done = 0;
    xfer_mode = 0; rdy_now = 1; rdy_pol = 0;
    rd_once(); check("R7 ready differs mode0", rd_data, 8'h3A);
    xfer_mode = 1; rd_once(); check("R7 mode1 masks ready", rd_data, 8'h38);
    xfer_mode = 2; rdy_pol = 1; rd_once(); check("R7 ready equal", rd_data, 8'h38);
    rdy_now = 0; rd_once(); check("R7 ready differs mode2", rd_data, 8'h3A);
    xfer_mode = 1; rdy_now = 1; rdy_pol = 0;
  endtask

  task automatic t_order();
    logic [7:0] exp [7];
    pulse(0, 7'h7F);
    exp = '{8'h00, 8'h34, 8'h12, 8'h78, 8'h56, 8'hBC, 8'h9A};
    for (int i = 0; i < 7; i++) begin
      rd_once();
      check("R2 source order", rd_data, (i == 0) ? stat_exp() : exp[i]);
    end
    rd_once();
    check("R5 wrap to status", rd_data, stat_exp());
    rd_once();
    check("R5 after wrap", rd_data, 8'h34);
  endtask

  task automatic t_sparse();
    pulse(0, 7'h2A);
    rd_once(); check("R5 sparse first", rd_data, 8'h34);
    rd_once(); check("R5 sparse second", rd_data, 8'h78);
    rd_once(); check("R5 sparse third", rd_data, 8'hBC);
    rd_once(); check("R5 sparse wrap", rd_data, 8'h34);
  endtask

  task automatic t_restart();
    pulse(0, 7'h2A);
    rd_once(); check("R3 before restart", rd_data, 8'h34);
    pulse(1, 7'h00);
    rd_once(); check("R3 restart keeps mask", rd_data, 8'h34);
    rd_once();
    pulse(0, 7'h50);
    rd_once(); check("R3 new mask first", rd_data, 8'h56);
    rd_once(); check("R3 new mask second", rd_data, 8'h9A);
  endtask

  task automatic t_status_only();
    pulse(0, 7'h7F);
    rd_once(); rd_once(); check("R4 precondition", rd_data, 8'h34);
    @(negedge clk) status_only = 1; mask_ld = 1; mask_in = 7'h06;
    @(negedge clk) status_only = 0; mask_ld = 0;
    ctl_en = 1;
    rd_once(); check("R4 status only", rd_data, stat_exp());
    rd_once(); check("R4 status only repeat", rd_data, stat_exp());
    ctl_en = 0;
  endtask

  task automatic t_live();
    pulse(0, 7'h03);
    block_done = 1;
    rd_once(); check("R9 live status", rd_data, stat_exp());
    byte_cnt = 16'hBEEF;
    rd_once(); check("R9 live counter", rd_data, 8'hEF);
    block_done = 0;
    rd_once(); check("R9 live status after change", rd_data, 8'h38);
    byte_cnt = 16'h1234;
  endtask

  task automatic t_hold();
    pulse(0, 7'h08);
    rd_once(); check("R10 read addr_a low", rd_data, 8'h78);
    @(negedge clk) addr_a = 16'h0000; ctl_en = 1; match_hit = 1;
    repeat (3) @(negedge clk);
    check("R10 hold without strobe", rd_data, 8'h78);
    pulse(1, 7'h00);
    check("R10 hold across restart", rd_data, 8'h78);
    addr_a = 16'h5678; ctl_en = 0; match_hit = 0;
  endtask

  task automatic t_collide();
    pulse(0, 7'h2A);
    rd_once();
    @(negedge clk) rd_stb = 1; seq_restart = 1;
    @(negedge clk) rd_stb = 0; seq_restart = 0;
    check("R11 read with restart uses old position", rd_data, 8'h78);
    rd_once(); check("R11 next read from start", rd_data, 8'h34);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rd_stb = 0; mask_ld = 0; seq_restart = 0; status_only = 0;
    mask_in = 0; ctl_en = 0; xfer_mode = 2'd1; rdy_now = 1; rdy_pol = 0;
    match_hit = 0; block_done = 0;
    byte_cnt = 16'h1234; addr_a = 16'h5678; addr_b = 16'h9ABC;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_status();
    t_order();
    t_sparse();
    t_restart();
    t_status_only();
    t_live();
    t_hold();
    t_collide();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule